// File: doc/BRIEF.md
# DMA Dual-Port Address Generator

This block produces the addresses for the two ports of a simple DMA engine. Each port keeps a programmable starting address and, apart from it, a live address counter that drives the port's address output. Whenever one byte has been moved, the engine pulses a transfer-done strobe. Each counter then moves up by one, moves down by one, or stays where it is, according to the mode of its port.

The starting registers act as a buffer in front of the live counters. Software can therefore write the next block's addresses while the current block is still running, and the active count is not disturbed. A load command copies both starting registers into both counters. An end-of-block input stands in for the byte-count logic. When the auto-restart bit is set, that input reloads the counters from the starting registers, so the same address sequence repeats without software help. Bus arbitration, the data path and the byte counting are outside this block.

A small register interface serves the CPU. Register 0 holds the port 0 start address and register 1 holds the port 1 start address. Register 2 holds the configuration. Reads of registers 0 and 1 return the live counters.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both counters, both starting registers and the configuration register are zero, which selects increment mode with auto-restart off.
- R2: A write to register 0 or 1 updates that port's starting register and leaves both counters unchanged in that cycle. This holds even while transfers are in progress.
- R3: When `load` is high at a clock edge, each counter takes the value of its starting register as it stood before that edge. A second `load` with no write in between gives the same addresses again.
- R4: In increment mode (mode code 00), each `xfer_done` pulse adds one to the counter, wrapping from 0xFFFF to 0x0000.
- R5: In decrement mode (mode code 01), each `xfer_done` pulse subtracts one from the counter, wrapping from 0x0000 to 0xFFFF.
- R6: In fixed mode (mode code 10, with 11 treated the same way), `xfer_done` leaves the counter unchanged.
- R7: A counter changes only on `load`, on `xfer_done`, or on `end_of_block` with auto-restart on. In every other cycle it holds its value.
- R8: If `load` and `xfer_done` arrive in the same cycle, the counters take the starting values and the step is not applied.
- R9: With auto-restart on (configuration bit 4), `end_of_block` reloads both counters from their starting registers. This reload takes priority over an `xfer_done` in the same cycle.
- R10: With auto-restart off, `end_of_block` has no effect, and an `xfer_done` in the same cycle still steps the counters.
- R11: `reg_rdata` follows `reg_addr` combinationally. Address 0 returns counter 0, address 1 returns counter 1, address 2 returns the configuration (bits 1:0 are the port 0 mode, bits 3:2 are the port 1 mode, bit 4 is auto-restart, and the upper bits are zero), and address 3 returns zero.
- R12: The two ports follow their own modes independently within the same transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| load | input | 1 | Copy both starting registers into both counters |
| xfer_done | input | 1 | One-cycle pulse after each byte transfer |
| end_of_block | input | 1 | Block-complete indication from the count logic |
| addr_p0 | output | 16 | Port 0 current address |
| addr_p1 | output | 16 | Port 1 current address |

## Verification
The assertions run on every cycle. They check that a load copies the previous starting value, that an increment step adds one, and that a decrement step subtracts one. They also check that a counter holds when it receives no event and when it is in fixed mode, and that a configuration write lands. Other behaviours only the bench's scenarios can show. These are the wrap at both ends of the address range, that a write to a starting register during a running transfer leaves the counter alone, and that reloading gives back the previous addresses. The bench also covers the priority of a reload over a step when both arrive together, and the effect of `end_of_block` with auto-restart on and off.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic [1:0] {
    MODE_INC  = 2'b00,
    MODE_DEC  = 2'b01,
    MODE_HOLD = 2'b10,
    MODE_HLD2 = 2'b11
  } mode_t;

  localparam int REG_W   = 2;
  localparam int CFG_W   = 5;
  localparam logic [REG_W-1:0] SEL_START0 = 2'd0;
  localparam logic [REG_W-1:0] SEL_START1 = 2'd1;
  localparam logic [REG_W-1:0] SEL_CFG    = 2'd2;
endpackage

// File: rtl/dma_addr_cfg.sv
module dma_addr_cfg
  import dma_addr_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DW-1:0]     cfg_wdata,
  output mode_t             port_mode [NPORTS],
  output logic              auto_restart
);
  localparam int MODE_BITS = 2 * NPORTS;

  logic [MODE_BITS-1:0] mode_q;
  logic                 auto_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      auto_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= cfg_wdata[MODE_BITS-1:0];
      auto_q <= cfg_wdata[MODE_BITS];
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_mode
    assign port_mode[p] = mode_t'(mode_q[2*p +: 2]);
  end
  assign auto_restart = auto_q;

  // R11: the configuration written is what later reads return
  assert_cfg_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (mode_q == $past(cfg_wdata[MODE_BITS-1:0]) && auto_q == $past(cfg_wdata[MODE_BITS])));
endmodule

// File: rtl/dma_addr_port.sv
module dma_addr_port
  import dma_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_we,
  input  logic [AW-1:0] start_wdata,
  input  mode_t         mode,
  input  logic          load,
  input  logic          restart,
  input  logic          step,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] ctr_q
);
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] cur, input mode_t m);
    case (m)
      MODE_INC: next_addr = cur + AW'(1);
      MODE_DEC: next_addr = cur - AW'(1);
      default:  next_addr = cur;
    endcase
  endfunction

  logic ev_load, ev_restart, ev_step, ev_any;
  assign ev_load    = load;
  assign ev_restart = restart & ~load;
  assign ev_step    = step & ~load & ~restart;
  assign ev_any     = ev_load | ev_restart | ev_step;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= '0;
    else if (start_we) start_q <= start_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctr_q <= '0;
    else if (ev_load || ev_restart) ctr_q <= start_q;
    else if (ev_step) ctr_q <= next_addr(ctr_q, mode);
  end

  assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> ctr_q == $past(start_q));
  assert_inc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && mode == MODE_INC) |=> ctr_q == $past(ctr_q) + AW'(1));
  assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && mode == MODE_DEC) |=> ctr_q == $past(ctr_q) - AW'(1));
  assert_fixed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && !ev_restart && mode[1]) |=> $stable(ctr_q));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_any |=> $stable(ctr_q));
  assert_restart_copies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ctr_q == $past(start_q));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          load,
  input  logic          xfer_done,
  input  logic          end_of_block,
  output logic [AW-1:0] addr_p0,
  output logic [AW-1:0] addr_p1
);
  localparam int NPORTS = 2;

  mode_t         port_mode [NPORTS];
  logic          auto_restart;
  logic          restart_ev;
  logic [AW-1:0] start_q [NPORTS];
  logic [AW-1:0] ctr_q   [NPORTS];
  logic          cfg_we;

  assign cfg_we     = reg_wr && (reg_addr == SEL_CFG);
  assign restart_ev = end_of_block & auto_restart;

  dma_addr_cfg #(.NPORTS(NPORTS), .DW(AW)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(reg_wdata),
    .port_mode(port_mode), .auto_restart(auto_restart)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic swe;
    assign swe = reg_wr && (reg_addr == REG_W'(p));
    dma_addr_port #(.AW(AW)) i_port (
      .clk(clk), .rst_n(rst_n), .start_we(swe), .start_wdata(reg_wdata),
      .mode(port_mode[p]), .load(load), .restart(restart_ev), .step(xfer_done),
      .start_q(start_q[p]), .ctr_q(ctr_q[p])
    );
  end

  assign addr_p0 = ctr_q[0];
  assign addr_p1 = ctr_q[1];

  always_comb begin
    case (reg_addr)
      SEL_START0: reg_rdata = ctr_q[0];
      SEL_START1: reg_rdata = ctr_q[1];
      SEL_CFG:    reg_rdata = AW'({auto_restart, port_mode[1], port_mode[0]});
      default:    reg_rdata = '0;
    endcase
  end

  // R10: with auto-restart off and no load, end_of_block alone leaves the counters alone
  assert_eob_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (end_of_block && !auto_restart && !load && !xfer_done) |=> ($stable(addr_p0) && $stable(addr_p1)));
endmodule

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        load = 1'b0, xfer_done = 1'b0, end_of_block = 1'b0;
  logic [15:0] addr_p0, addr_p1;

  always #4 clk = ~clk;

  dma_addr_gen i_dma_addr_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .load(load),
    .xfer_done(xfer_done), .end_of_block(end_of_block),
    .addr_p0(addr_p0), .addr_p1(addr_p1)
  );

  typedef struct { string req; logic [15:0] e0; logic [15:0] e1; } item_t;
  item_t sb[$];
  int n_cmp = 0, n_bad = 0;

  logic [15:0] m_start [2];
  logic [15:0] m_ctr   [2];
  logic [4:0]  m_cfg;

  function automatic logic [15:0] model_step(logic [15:0] v, logic [1:0] m);
    if (m == 2'b00) return v + 16'd1;
    if (m == 2'b01) return v - 16'd1;
    return v;
  endfunction

  // monitor: pops expected items and compares with the port outputs
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (addr_p0 !== it.e0 || addr_p1 !== it.e1) begin
        n_bad++;
        $display("FAIL %s: got %h/%h expected %h/%h", it.req, addr_p0, addr_p1, it.e0, it.e1);
      end
    end
  end

  task automatic cyc(string req, bit wr, logic [1:0] wa, logic [15:0] wd, bit ld, bit xd, bit eob);
    logic [15:0] os [2];
    reg_wr = wr; reg_addr = wa; reg_wdata = wd; load = ld; xfer_done = xd; end_of_block = eob;
    @(posedge clk);
    os = m_start;
    for (int p = 0; p < 2; p++) begin
      if (ld || (eob && m_cfg[4])) m_ctr[p] = os[p];
      else if (xd) m_ctr[p] = model_step(m_ctr[p], m_cfg[2*p +: 2]);
    end
    if (wr && wa < 2) m_start[wa] = wd;
    if (wr && wa == 2) m_cfg = wd[4:0];
    sb.push_back('{req, m_ctr[0], m_ctr[1]});
    @(negedge clk);
    reg_wr = 0; load = 0; xfer_done = 0; end_of_block = 0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [15:0] exp);
    reg_addr = a;
    #1;
    n_cmp++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata[%0d] got %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_start = '{16'h0, 16'h0}; m_ctr = '{16'h0, 16'h0}; m_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 2'd0, 16'h0); rd("R1", 2'd1, 16'h0); rd("R1", 2'd2, 16'h0);
    // R2 start writes leave counters
    cyc("R2", 1, 2'd0, 16'h1000, 0, 0, 0);
    cyc("R2", 1, 2'd1, 16'h2000, 0, 0, 0);
    // R3 load
    cyc("R3", 0, 2'd0, 16'h0, 1, 0, 0);
    // R4 increment
    for (int i = 0; i < 3; i++) cyc("R4", 0, 2'd0, 16'h0, 0, 1, 0);
    // R7 idle
    cyc("R7", 0, 2'd0, 16'h0, 0, 0, 0);
    // R12 port0 dec, port1 fixed
    cyc("R12", 1, 2'd2, 16'h0009, 0, 0, 0);
    cyc("R5", 0, 2'd0, 16'h0, 0, 1, 0);
    cyc("R6", 0, 2'd0, 16'h0, 0, 1, 0);
    // R2 write start during a step
    cyc("R2", 1, 2'd0, 16'hFFFF, 0, 1, 0);
    // R8 load beats step
    cyc("R8", 0, 2'd0, 16'h0, 1, 1, 0);
    // R4 wrap up, R5 on port1
    cyc("R12", 1, 2'd2, 16'h0004, 0, 0, 0);
    cyc("R4", 0, 2'd0, 16'h0, 0, 1, 0);
    cyc("R2", 1, 2'd1, 16'h0000, 0, 0, 0);
    cyc("R3", 0, 2'd0, 16'h0, 1, 0, 0);
    cyc("R5", 0, 2'd0, 16'h0, 0, 1, 0);
    // R10 auto off
    cyc("R10", 0, 2'd0, 16'h0, 0, 0, 1);
    cyc("R10", 0, 2'd0, 16'h0, 0, 1, 1);
    // R9 auto on
    cyc("R9", 1, 2'd2, 16'h0014, 0, 0, 0);
    cyc("R9", 0, 2'd0, 16'h0, 0, 1, 0);
    cyc("R9", 0, 2'd0, 16'h0, 0, 0, 1);
    cyc("R9", 0, 2'd0, 16'h0, 0, 1, 0);
    cyc("R9", 0, 2'd0, 16'h0, 0, 1, 1);
    // R3 reload previous addresses
    cyc("R3", 0, 2'd0, 16'h0, 0, 1, 0);
    cyc("R3", 0, 2'd0, 16'h0, 1, 0, 0);
    // R6 mode code 11 holds
    cyc("R6", 1, 2'd2, 16'h000F, 0, 0, 0);
    cyc("R6", 0, 2'd0, 16'h0, 0, 1, 0);
    cyc("R6", 1, 2'd2, 16'h0001, 0, 0, 0);
    cyc("R5", 0, 2'd0, 16'h0, 0, 1, 0);
    // R11 readback
    rd("R11", 2'd0, m_ctr[0]);
    rd("R11", 2'd1, m_ctr[1]);
    rd("R11", 2'd2, 16'h0001);
    rd("R11", 2'd3, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule